// File: doc/BRIEF.md
# Iterative Baugh-Wooley Shift-Add Multiplier

This block multiplies two 32-bit operands for an integer execution stage, one partial-product row per clock. It returns either the low word of the product, or the high word with each operand independently treated as signed or unsigned. That covers the usual low multiply and the signed×signed, signed×unsigned and unsigned×unsigned high multiplies. The block owns no adder. On every step it drives two 33-bit addends to an adder shared with the rest of the stage and captures the 34-bit sum that comes back.

The low-word product adds left-shifted copies of A into a 32-bit accumulator and shifts B right. It stops as soon as no set bit of B remains. The high-word product runs a right-shifting accumulator through all 32 rows. Sign handling follows the Baugh-Wooley method: selected row bits are inverted, a correction term is preset into the accumulator on the first step, and the top result bit is flipped at the end. The operands are never sign-extended. The surrounding stage holds enable and the operands steady until valid appears. Dropping enable abandons the operation.

Top module: `shift_add_mul`

## Requirements
- R1: With `hi_word_i` = 0 the result on the valid cycle equals bits 31:0 of A×B, whatever `sgn_i` holds.
- R2: With `hi_word_i` = 1 the result on the valid cycle equals bits 63:32 of A×B. A is taken as two's complement when `sgn_i[0]` is 1 and B when `sgn_i[1]` is 1; otherwise each is unsigned.
- R3: A low-word operation raises `valid_o` after S rising edges with enable high, where S is the index of B's highest set bit plus one, and S is 1 when B is 0.
- R4: A high-word operation raises `valid_o` after exactly 32 rising edges with enable high, for any operand values.
- R5: `valid_o` stays high for a single cycle and is low on the next cycle even if `en_i` stays high.
- R6: On the first step of a low-word operation `add_a_o` is 0. `add_b_o` is {0, A} when B bit 0 is 1 and 0 when B bit 0 is 0.
- R7: If `en_i` is low during a cycle, `valid_o` is low in the following cycle. An abandoned operation never raises `valid_o`, and the next operation completes normally.
- R8: While `rst_ni` is low, `valid_o` is low. The reset is asynchronous, and an operation started after reset completes normally.
- R9: On the first step of a high-word operation `add_a_o` carries the sign correction: 2^32 when both mode bits are 1, 2^31 when exactly one is 1, and 0 when both are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Operation request; hold high until valid |
| hi_word_i | input | 1 | 0: low word of product, 1: high word |
| sgn_i | input | 2 | Bit 0: A signed, bit 1: B signed |
| a_i | input | 32 | Multiplicand A |
| b_i | input | 32 | Multiplier B |
| add_a_o | output | 33 | Accumulator addend to shared adder |
| add_b_o | output | 33 | Partial-product addend to shared adder |
| add_sum_i | input | 34 | Sum returned by shared adder |
| valid_o | output | 1 | Result valid, one cycle |
| result_o | output | 32 | Product word |

## Verification
The multiply is exercised with zero, one, all-ones and the most negative value under each of the four signedness modes. These operands separate a wrong Baugh-Wooley inversion or correction term from a correct one, because they are the values where sign handling changes the high word. Values of B with only a high bit set drive the low-word path to its longest run, while B of 0 and 1 drive it to its shortest, so latency errors in early termination show up. The first-step adder operands are inspected directly, which separates a wrong preset from a wrong row pattern. Aborts and a reset in mid-operation confirm that no stale result escapes.

// File: rtl/smul_pkg.sv
package smul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_DONE = 2'd3
  } smul_state_e;

endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        hi_word_i,
  input  logic        last_step_i,
  output logic        is_idle_o,
  output logic        step_en_o,
  output logic        valid_o,
  output smul_state_e state_o
);

  smul_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (en_i) begin
          if (last_step_i)    state_d = ST_DONE;
          else if (hi_word_i) state_d = ST_HIGH;
          else                state_d = ST_LOW;
        end
      end
      ST_LOW, ST_HIGH: begin
        if (!en_i)            state_d = ST_IDLE;
        else if (last_step_i) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign is_idle_o = (state_q == ST_IDLE);
  assign step_en_o = en_i && (state_q != ST_DONE);
  assign valid_o   = (state_q == ST_DONE);
  assign state_o   = state_q;

endmodule

// File: rtl/smul_datapath.sv
module smul_datapath #(
  parameter int W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           is_idle_i,
  input  logic           step_en_i,
  input  logic           hi_word_i,
  input  logic [1:0]     sgn_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W:0]     add_a_o,
  output logic [W:0]     add_b_o,
  input  logic [W+1:0]   add_sum_i,
  output logic           last_step_o,
  output logic [W-1:0]   result_o
);

  localparam int CW = $clog2(W);

  // Partial-product row with Baugh-Wooley inversions applied.
  function automatic logic [W-1:0] bw_row(input logic [W-1:0] mc, input logic bit_b,
                                          input logic inv_lo, input logic inv_hi);
    logic [W-1:0] r;
    r = mc & {W{bit_b}};
    r[W-2:0] = r[W-2:0] ^ {(W-1){inv_lo}};
    r[W-1]   = r[W-1] ^ inv_hi;
    return r;
  endfunction

  // Low part of the Baugh-Wooley correction, loaded on the first step.
  function automatic logic [W:0] bw_preset(input logic sa, input logic sb);
    logic [W:0] p;
    p = '0;
    if (sa && sb)      p[W]   = 1'b1;
    else if (sa || sb) p[W-1] = 1'b1;
    return p;
  endfunction

  logic [W:0]    acc_q, acc_d, cur_acc;
  logic [W-1:0]  mcand_q, mcand_d, cur_mcand;
  logic [W-1:0]  mplier_q, mplier_d, cur_mplier;
  logic [CW-1:0] cnt_q, cnt_d, cur_cnt;
  logic          last_row, neg_row;
  logic [W-1:0]  hi_row, lo_row;

  always_comb begin
    cur_acc    = is_idle_i ? (hi_word_i ? bw_preset(sgn_i[0], sgn_i[1]) : '0) : acc_q;
    cur_mcand  = is_idle_i ? a_i : mcand_q;
    cur_mplier = is_idle_i ? b_i : mplier_q;
    cur_cnt    = is_idle_i ? '0 : cnt_q;

    last_row = (cur_cnt == CW'(W - 1));
    neg_row  = last_row && sgn_i[1];
    hi_row   = bw_row(cur_mcand, cur_mplier[0], neg_row, sgn_i[0] ^ neg_row);
    lo_row   = cur_mplier[0] ? cur_mcand : '0;

    add_a_o = hi_word_i ? cur_acc : {1'b0, cur_acc[W-1:0]};
    add_b_o = {1'b0, hi_word_i ? hi_row : lo_row};

    last_step_o = hi_word_i ? last_row : (cur_mplier[W-1:1] == '0);

    cnt_d = cur_cnt + CW'(1);
    if (hi_word_i) begin
      acc_d    = add_sum_i[W+1:1];
      mplier_d = {add_sum_i[0], cur_mplier[W-1:1]};
      mcand_d  = cur_mcand;
    end else begin
      acc_d    = {1'b0, add_sum_i[W-1:0]};
      mplier_d = cur_mplier >> 1;
      mcand_d  = cur_mcand << 1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
    end else if (step_en_i) begin
      acc_q    <= acc_d;
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
      cnt_q    <= cnt_d;
    end
  end

  // The remaining correction term, 2^(2W-1), is a flip of the top result bit.
  assign result_o = hi_word_i ? (acc_q[W-1:0] ^ {(sgn_i != 2'b00), {(W-1){1'b0}}})
                              : acc_q[W-1:0];

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
  import smul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           hi_word_i,
  input  logic [1:0]     sgn_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W:0]     add_a_o,
  output logic [W:0]     add_b_o,
  input  logic [W+1:0]   add_sum_i,
  output logic           valid_o,
  output logic [W-1:0]   result_o
);

  logic        is_idle;
  logic        step_fire;
  logic        last_step;
  smul_state_e state;

  smul_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .hi_word_i   (hi_word_i),
    .last_step_i (last_step),
    .is_idle_o   (is_idle),
    .step_en_o   (step_fire),
    .valid_o     (valid_o),
    .state_o     (state)
  );

  smul_datapath #(.W(W)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .is_idle_i   (is_idle),
    .step_en_i   (step_fire),
    .hi_word_i   (hi_word_i),
    .sgn_i       (sgn_i),
    .a_i         (a_i),
    .b_i         (b_i),
    .add_a_o     (add_a_o),
    .add_b_o     (add_b_o),
    .add_sum_i   (add_sum_i),
    .last_step_o (last_step),
    .result_o    (result_o)
  );

endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic         hi_word_i,
  input logic [1:0]   sgn_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         valid_o,
  input logic [W-1:0] result_o,
  input logic         step_fire,
  input logic         last_step
);

  localparam int RW = $clog2(W + 1) + 1;

  function automatic logic [RW-1:0] want_steps(input logic [W-1:0] b);
    logic [RW-1:0] n;
    n = '0;
    for (int i = 0; i < W; i++) if (b[i]) n = RW'(i + 1);
    if (n == '0) n = RW'(1);
    return n;
  endfunction

  function automatic logic [W-1:0] want_hi(input logic [1:0] md, input logic [W-1:0] a,
                                           input logic [W-1:0] b);
    logic [2*W-1:0] ea, eb, pr;
    ea = {{W{md[0] & a[W-1]}}, a};
    eb = {{W{md[1] & b[W-1]}}, b};
    pr = ea * eb;
    return pr[2*W-1:W];
  endfunction

  function automatic logic [W-1:0] want_lo(input logic [W-1:0] a, input logic [W-1:0] b);
    return a * b;
  endfunction

  logic [RW-1:0] run_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                run_cnt <= '0;
    else if (!en_i || valid_o)  run_cnt <= '0;
    else                        run_cnt <= run_cnt + RW'(1);
  end

  AST_LO_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !hi_word_i |-> result_o == want_lo(a_i, b_i));                  // R1
  AST_HI_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && hi_word_i |-> result_o == want_hi(sgn_i, a_i, b_i));            // R2
  AST_LO_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !hi_word_i |-> run_cnt == want_steps(b_i));                     // R3
  AST_HI_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && hi_word_i |-> run_cnt == RW'(W));                               // R4
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(step_fire && last_step));                         // R3
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);                                                     // R5
  AST_ABORT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_o);                                                       // R7

  always @(negedge clk_i) begin
    if (!rst_ni) AST_RESET_QUIET: assert (!valid_o);                           // R8
  end

endmodule

bind shift_add_mul smul_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .hi_word_i (hi_word_i),
  .sgn_i     (sgn_i),
  .a_i       (a_i),
  .b_i       (b_i),
  .valid_o   (valid_o),
  .result_o  (result_o),
  .step_fire (step_fire),
  .last_step (last_step)
);

// File: tb/tb_shift_add_mul.sv
module tb_shift_add_mul;

  localparam int NV = 20;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        en = 1'b0;
  logic        hi = 1'b0;
  logic [1:0]  md = 2'b00;
  logic [31:0] a_in = '0, b_in = '0;
  logic [32:0] add_a, add_b;
  logic [33:0] add_sum;
  logic        valid;
  logic [31:0] result;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  // Shared adder model outside the block.
  assign add_sum = {1'b0, add_a} + {1'b0, add_b};

  shift_add_mul dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .hi_word_i(hi), .sgn_i(md),
    .a_i(a_in), .b_i(b_in), .add_a_o(add_a), .add_b_o(add_b),
    .add_sum_i(add_sum), .valid_o(valid), .result_o(result)
  );

  // {high word, mode, A, B}
  localparam logic [66:0] VEC [NV] = '{
    {1'b0, 2'd0, 32'd7,         32'd6},
    {1'b0, 2'd3, 32'hFFFFFFFF,  32'hFFFFFFFF},
    {1'b0, 2'd1, 32'h12345678,  32'h9ABCDEF1},
    {1'b0, 2'd0, 32'hDEADBEEF,  32'h00000000},
    {1'b0, 2'd2, 32'h80000000,  32'h00000001},
    {1'b0, 2'd0, 32'd5,         32'h80000000},
    {1'b0, 2'd0, 32'h0000FFFF,  32'h00000100},
    {1'b1, 2'd3, 32'hFFFFFFFF,  32'hFFFFFFFF},
    {1'b1, 2'd3, 32'h80000000,  32'h80000000},
    {1'b1, 2'd3, 32'h80000000,  32'hFFFFFFFF},
    {1'b1, 2'd3, 32'h12345678,  32'h9ABCDEF1},
    {1'b1, 2'd3, 32'h00000000,  32'h12345678},
    {1'b1, 2'd3, 32'h00000001,  32'hFFFFFFFF},
    {1'b1, 2'd1, 32'hFFFFFFFF,  32'h00000001},
    {1'b1, 2'd1, 32'h80000000,  32'hFFFFFFFF},
    {1'b1, 2'd1, 32'h00000007,  32'h80000000},
    {1'b1, 2'd0, 32'hFFFFFFFF,  32'hFFFFFFFF},
    {1'b1, 2'd0, 32'h80000000,  32'h80000000},
    {1'b1, 2'd2, 32'h00000005,  32'hFFFFFFFD},
    {1'b1, 2'd2, 32'hFFFFFFFF,  32'h80000000}
  };

  function automatic logic [63:0] ref_prod(input logic [1:0] m, input logic [31:0] a,
                                           input logic [31:0] b);
    logic signed [64:0] sa, sb;
    sa = m[0] ? 65'($signed(a)) : {33'd0, a};
    sb = m[1] ? 65'($signed(b)) : {33'd0, b};
    return 64'(sa * sb);
  endfunction

  function automatic int ref_edges(input logic h, input logic [31:0] b);
    int n;
    if (h) return 32;
    n = 1;
    for (int i = 31; i >= 0; i--) if (b[i]) begin n = i + 1; break; end
    return n;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start_op(input logic h, input logic [1:0] m, input logic [31:0] a,
                          input logic [31:0] b);
    @(negedge clk);
    hi = h; md = m; a_in = a; b_in = b; en = 1'b1;
  endtask

  task automatic run_op(input logic h, input logic [1:0] m, input logic [31:0] a,
                        input logic [31:0] b, output logic [31:0] res, output int edges);
    start_op(h, m, a, b);
    edges = 0;
    do begin
      @(negedge clk);
      edges++;
    end while (!valid && edges < 100);
    res = result;
    en = 1'b0;
  endtask

  task automatic check_op(input logic h, input logic [1:0] m, input logic [31:0] a,
                          input logic [31:0] b);
    logic [31:0] r;
    logic [63:0] p;
    int e;
    run_op(h, m, a, b, r, e);
    p = ref_prod(m, a, b);
    if (h) begin
      check("R2 high word", {32'd0, r}, {32'd0, p[63:32]});
      check("R4 high latency", 64'(e), 64'(32));
    end else begin
      check("R1 low word", {32'd0, r}, {32'd0, p[31:0]});
      check("R3 low latency", 64'(e), 64'(ref_edges(1'b0, b)));
    end
  endtask

  task automatic peek_first(input logic h, input logic [1:0] m, input logic [31:0] a,
                            input logic [31:0] b, output logic [32:0] pa,
                            output logic [32:0] pb);
    start_op(h, m, a, b);
    #1;
    pa = add_a;
    pb = add_b;
    en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [32:0] pa, pb;
    logic        seen;

    #2 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 valid low in reset", {63'd0, valid}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R8 valid low after reset", {63'd0, valid}, 64'd0);

    for (int i = 0; i < NV; i++)
      check_op(VEC[i][66], VEC[i][65:64], VEC[i][63:32], VEC[i][31:0]);

    // R6: first-step adder operands for a low-word operation
    peek_first(1'b0, 2'd0, 32'h00001234, 32'h00000003, pa, pb);
    check("R6 acc addend zero", {31'd0, pa}, 64'd0);
    check("R6 row addend is A", {31'd0, pb}, 64'h1234);
    peek_first(1'b0, 2'd0, 32'h00001234, 32'h00000002, pa, pb);
    check("R6 row addend zero for B bit 0 clear", {31'd0, pb}, 64'd0);

    // R9: Baugh-Wooley preset on the accumulator addend
    peek_first(1'b1, 2'd3, 32'd5, 32'd1, pa, pb);
    check("R9 preset both signed", {31'd0, pa}, 64'h1_0000_0000);
    peek_first(1'b1, 2'd1, 32'd5, 32'd1, pa, pb);
    check("R9 preset A signed", {31'd0, pa}, 64'h8000_0000);
    peek_first(1'b1, 2'd2, 32'd5, 32'd1, pa, pb);
    check("R9 preset B signed", {31'd0, pa}, 64'h8000_0000);
    peek_first(1'b1, 2'd0, 32'd5, 32'd1, pa, pb);
    check("R9 preset unsigned", {31'd0, pa}, 64'd0);

    // R5: valid lasts one cycle while enable stays high
    start_op(1'b0, 2'd0, 32'd9, 32'd3);
    do @(negedge clk); while (!valid);
    check("R5 result on pulse", {32'd0, result}, 64'd27);
    @(negedge clk);
    check("R5 valid drops with enable held", {63'd0, valid}, 64'd0);
    en = 1'b0;

    // R7: abort a high-word operation
    start_op(1'b1, 2'd3, 32'h80000000, 32'h80000000);
    repeat (5) @(negedge clk);
    en = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      seen = seen | valid;
    end
    check("R7 no valid after abort", {63'd0, seen}, 64'd0);
    check_op(1'b1, 2'd0, 32'hFFFFFFFF, 32'hFFFFFFFF);

    // R8: reset in mid-operation
    start_op(1'b1, 2'd1, 32'h0000ABCD, 32'hFFFF0000);
    repeat (10) @(negedge clk);
    rst_ni = 1'b0;
    en = 1'b0;
    #1;
    check("R8 async reset clears valid", {63'd0, valid}, 64'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    check_op(1'b1, 2'd1, 32'hFFFFFFFE, 32'h00000003);
    check_op(1'b0, 2'd3, 32'h80000000, 32'h80000000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule